// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a register-mapped timer with several independent down-counters. Each channel has a control word, a reload (interval) value and a count value that can be read back at any time. A channel picks one of four tick-enable inputs as its time base and divides it by a power of two. It then counts down once per divided tick. When a channel expires it raises a sticky per-channel status bit. It then either reloads and keeps going (periodic mode) or stops at zero (one-shot mode).

A per-channel enable mask gates the status bits onto a single interrupt line. Software clears a status bit by writing a one to it. Turning a channel off does not stop it at once: it runs on for a fixed number of source ticks before it halts, so software that measures delays must allow for that run-on. An all-ones interval gives a full-range free-running counter. Its bitwise inverse is a monotonic up-count of elapsed ticks.

Top module: `mtimer_top`

## Requirements
- R1: The enable mask is at offset 0x00 and the status bits are at offset 0x04, with bit n belonging to channel n. Channel n has its control word at 0x10·(n+1), its interval at 0x10·(n+1)+0x4 and its count at 0x10·(n+1)+0x8. The interval reads back as written. Writes to the count offset are ignored.
- R2: Control bit fields are: bit 0 run enable; bit 1 load request; bits 3:2 source index; bits 6:4 divider code; bit 7 one-shot when 1, periodic when 0. The word reads back with all higher bits zero. The load request reads 0 once it has been served.
- R3: A write that sets both enable and load request starts the channel. The first divided tick copies the interval into the count. Each later tick lowers the count by one, and the tick that finds the count at zero is the expiry. With an always-high source, expiry happens (I+2)·2^p clock cycles after the write edge, where I is the interval and p the divider code.
- R4: Divider code p (0 to 7) produces one divided tick per 2^p selected source ticks.
- R5: In periodic mode the expiry reloads the interval, and later expiries are (I+1)·2^p source ticks apart.
- R6: In one-shot mode the expiry clears the enable bit (control reads back with bit 0 low). The count then holds at zero.
- R7: Expiry sets the channel's status bit. The bit stays set until a one is written to it, and writing a zero leaves it set. If expiry and clear fall in the same cycle, expiry wins.
- R8: The interrupt output is high exactly when some channel has both its status bit and its mask bit set.
- R9: After software clears the enable bit of a running channel, the channel keeps counting for 2 more selected source ticks, then stops, and its count holds.
- R10: A channel counts only on cycles where its selected source input is high. With no source ticks, its count and status do not change.
- R11: With an all-ones interval and divider code 0, the inverted count read j ticks after the load equals j.
- R12: After reset all registers read zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Tick-enable per time-base source |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench tries the countdown with a source that is always high, across random intervals, divider codes, channels and both modes. The cycle of expiry pins down where the load tick falls and how much the divider divides by. It also tries a sparse, irregular pulse train on another source. There, expiry must follow the count of pulses and not the cycles that pass, which tells source selection apart from the clock itself. An all-ones interval shows the inverted up-count. The disable run-on is shown by reading the count on each cycle after the write. Mask gating, write-zero immunity and write-one clear of the status bits each get directed checks.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
    localparam int SRC_W = 2;
    localparam int PRE_W = 3;
    localparam int NSRC  = 1 << SRC_W;

    typedef struct packed {
        logic             oneshot;
        logic [PRE_W-1:0] pre;
        logic [SRC_W-1:0] src;
        logic             load;
        logic             en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/mtimer_prescale.sv
module mtimer_prescale
    import mtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_in,
    input  logic [PRE_W-1:0] code,
    output logic             tick
);
    localparam int PCW = (1 << PRE_W) - 1;

    logic [PCW-1:0] pre_d, pre_q;
    logic [PCW-1:0] mask;

    always_comb begin
        for (int i = 0; i < PCW; i++) begin
            mask[i] = (i < int'(code));
        end
        tick  = run && src_in && ((pre_q & mask) == mask);
        pre_d = pre_q;
        if (!run) begin
            pre_d = '0;
        end else if (src_in) begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R4
    prescale_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q == '0));
endmodule

// File: rtl/mtimer_chan.sv
module mtimer_chan
    import mtimer_pkg::*;
#(
    parameter int CW         = 32,
    parameter int SYNC_TICKS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_tick,
    input  logic            wr_ctl,
    input  logic            wr_int,
    input  logic [CW-1:0]   wdata,
    output logic [CW-1:0]   ctl_rd,
    output logic [CW-1:0]   int_rd,
    output logic [CW-1:0]   cnt_rd,
    output logic            expire
);
    localparam int SCW = $clog2(SYNC_TICKS + 1);

    typedef struct packed {
        ctl_t           ctl;
        logic [CW-1:0]  intv;
        logic [CW-1:0]  cnt;
        logic           run;
        logic           stop_pend;
        logic [SCW-1:0] stop_cnt;
    } chan_st_t;

    chan_st_t s_d, s_q;
    ctl_t     ctl_new;
    logic     src_sel;
    logic     tick;

    assign src_sel = src_tick[s_q.ctl.src];

    mtimer_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.run),
        .src_in(src_sel),
        .code  (s_q.ctl.pre),
        .tick  (tick)
    );

    always_comb begin
        s_d     = s_q;
        expire  = 1'b0;
        ctl_new = ctl_t'(wdata[CTL_W-1:0]);

        // countdown on divided ticks
        if (tick) begin
            if (s_q.ctl.load) begin
                s_d.cnt      = s_q.intv;
                s_d.ctl.load = 1'b0;
            end else if (s_q.cnt == '0) begin
                expire = 1'b1;
                if (s_q.ctl.oneshot) begin
                    s_d.ctl.en    = 1'b0;
                    s_d.run       = 1'b0;
                    s_d.stop_pend = 1'b0;
                end else begin
                    s_d.cnt = s_q.intv;
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end

        // run-on after software disable, in source ticks
        if (s_q.stop_pend && src_sel) begin
            if (s_q.stop_cnt == SCW'(SYNC_TICKS - 1)) begin
                s_d.run       = 1'b0;
                s_d.stop_pend = 1'b0;
            end else begin
                s_d.stop_cnt = s_q.stop_cnt + 1'b1;
            end
        end

        if (wr_ctl) begin
            s_d.ctl = ctl_new;
            if (ctl_new.en) begin
                s_d.run       = 1'b1;
                s_d.stop_pend = 1'b0;
            end else if (s_q.run && !s_q.stop_pend) begin
                s_d.stop_pend = 1'b1;
                s_d.stop_cnt  = '0;
            end
        end

        if (wr_int) begin
            s_d.intv = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_rd = {{(CW-CTL_W){1'b0}}, s_q.ctl};
    assign int_rd = s_q.intv;
    assign cnt_rd = s_q.cnt;

    // R6
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && s_q.ctl.oneshot && !wr_ctl) |=> (!s_q.run && s_q.cnt == '0 && !s_q.ctl.en));
    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !s_q.ctl.oneshot && !wr_int) |=> (s_q.cnt == $past(s_q.intv)));
    // R9
    runon_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stop_pend |-> (s_q.stop_cnt < SCW'(SYNC_TICKS)));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.run |=> $stable(s_q.cnt));
    // R3
    load_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.ctl.load && !wr_ctl && !wr_int) |=> (!s_q.ctl.load && s_q.cnt == s_q.intv));
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
    import mtimer_pkg::*;
#(
    parameter int NCH        = 3,
    parameter int CW         = 32,
    parameter int AW         = 8,
    parameter int SYNC_TICKS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_tick,
    input  logic [AW-1:0]   bus_addr,
    input  logic [CW-1:0]   bus_wdata,
    input  logic            bus_we,
    output logic [CW-1:0]   bus_rdata,
    output logic            irq
);
    localparam logic [AW-1:0] MASK_OFS = AW'(0);
    localparam logic [AW-1:0] STAT_OFS = AW'(4);
    localparam logic [3:0]    CTL_SUB  = 4'h0;
    localparam logic [3:0]    INT_SUB  = 4'h4;
    localparam logic [3:0]    CNT_SUB  = 4'h8;

    typedef struct packed {
        logic [NCH-1:0] msk;
        logic [NCH-1:0] sta;
    } top_st_t;

    top_st_t        s_d, s_q;
    logic [NCH-1:0] blk_hit, wr_ctl, wr_int, expire;
    logic [CW-1:0]  ctl_rd [NCH];
    logic [CW-1:0]  int_rd [NCH];
    logic [CW-1:0]  cnt_rd [NCH];
    logic           wr_stat;

    assign wr_stat = bus_we && (bus_addr == STAT_OFS);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign blk_hit[n] = (bus_addr[AW-1:4] == (AW-4)'(n + 1));
        assign wr_ctl[n]  = bus_we && blk_hit[n] && (bus_addr[3:0] == CTL_SUB);
        assign wr_int[n]  = bus_we && blk_hit[n] && (bus_addr[3:0] == INT_SUB);

        mtimer_chan #(
            .CW        (CW),
            .SYNC_TICKS(SYNC_TICKS)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_tick(src_tick),
            .wr_ctl  (wr_ctl[n]),
            .wr_int  (wr_int[n]),
            .wdata   (bus_wdata),
            .ctl_rd  (ctl_rd[n]),
            .int_rd  (int_rd[n]),
            .cnt_rd  (cnt_rd[n]),
            .expire  (expire[n])
        );

        // R7
        status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire[n] |=> s_q.sta[n]);
        // R7
        status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.sta[n] && !(wr_stat && bus_wdata[n])) |=> s_q.sta[n]);
    end

    always_comb begin
        s_d = s_q;
        if (bus_we && bus_addr == MASK_OFS) begin
            s_d.msk = bus_wdata[NCH-1:0];
        end
        if (wr_stat) begin
            s_d.sta = s_q.sta & ~bus_wdata[NCH-1:0];
        end
        s_d.sta = s_d.sta | expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == MASK_OFS) begin
            bus_rdata = {{(CW-NCH){1'b0}}, s_q.msk};
        end else if (bus_addr == STAT_OFS) begin
            bus_rdata = {{(CW-NCH){1'b0}}, s_q.sta};
        end
        for (int n = 0; n < NCH; n++) begin
            if (blk_hit[n]) begin
                case (bus_addr[3:0])
                    CTL_SUB: bus_rdata = ctl_rd[n];
                    INT_SUB: bus_rdata = int_rd[n];
                    CNT_SUB: bus_rdata = cnt_rd[n];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    assign irq = |(s_q.msk & s_q.sta);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.msk == '0) |-> !irq);
    // R12
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && s_q == '0));
endmodule

// File: tb/sim_mtimer_top.sv
`timescale 1ns/1ps
module sim_mtimer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_v = 4'b0001;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        irq;
    int          cyc = 0;
    int          tests = 0;
    int          fails = 0;
    bit          done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mtimer_top u0 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_v), .bus_addr(addr),
        .bus_wdata(wdata), .bus_we(we), .bus_rdata(rdata), .irq(irq)
    );

    function automatic logic [7:0] a_ctl(int n); return 8'(16 * (n + 1));     endfunction
    function automatic logic [7:0] a_int(int n); return 8'(16 * (n + 1) + 4); endfunction
    function automatic logic [7:0] a_cnt(int n); return 8'(16 * (n + 1) + 8); endfunction
    function automatic int exp_first(int ival, int p); return (ival + 2) << p; endfunction
    function automatic int exp_period(int ival, int p); return (ival + 1) << p; endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq(int maxc, output int at);
        at = -1;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (irq) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic pulse_src1();
        src_v[1] = 1'b1;
        @(negedge clk);
        src_v[1] = 1'b0;
        idle(1 + int'($urandom % 3));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0;
        int k, at, at2;
        void'($urandom(32'd7041));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(8'h00, v); chk("R12 mask", v, 0);
        rd(8'h04, v); chk("R12 status", v, 0);
        for (int n = 0; n < 3; n++) begin
            rd(a_ctl(n), v); chk("R12 ctl", v, 0);
            rd(a_int(n), v); chk("R12 int", v, 0);
            rd(a_cnt(n), v); chk("R12 cnt", v, 0);
        end
        chk("R12 irq", {31'b0, irq}, 0);

        // R1 map
        wr(a_int(1), 32'hA5A5_1234);
        wr(a_int(2), 32'h0000_BEEF);
        wr(a_cnt(1), 32'h0000_0055);
        rd(a_int(1), v); chk("R1 int1", v, 32'hA5A5_1234);
        rd(a_int(2), v); chk("R1 int2", v, 32'h0000_BEEF);
        rd(a_cnt(1), v); chk("R1 cnt ro", v, 0);
        wr(8'h00, 32'h7);
        rd(8'h00, v); chk("R1 mask", v, 32'h7);

        // R3 + R6 directed one-shot on ch0
        wr(8'h00, 32'h1);
        wr(a_int(0), 5);
        wr(a_ctl(0), 32'h83);
        k = cyc;
        wait_irq(100, at);
        chk("R3 expiry cycle", at - k, exp_first(5, 0));
        rd(a_ctl(0), v); chk("R6 R2 ctl after oneshot", v, 32'h80);
        rd(a_cnt(0), v); chk("R6 cnt zero", v, 0);
        idle(5);
        rd(a_cnt(0), v); chk("R6 cnt holds", v, 0);

        // R7 write zero / write one
        wr(8'h04, 32'h0);
        rd(8'h04, v); chk("R7 write0 keeps", v, 32'h1);
        wr(8'h04, 32'h1);
        rd(8'h04, v); chk("R7 write1 clears", v, 0);
        chk("R8 irq low after clear", {31'b0, irq}, 0);

        // R8 gating
        wr(8'h00, 32'h0);
        wr(a_int(0), 2);
        wr(a_ctl(0), 32'h83);
        idle(10);
        chk("R8 masked irq", {31'b0, irq}, 0);
        rd(8'h04, v); chk("R7 status under mask", v, 32'h1);
        wr(8'h00, 32'h1);
        chk("R8 unmasked irq", {31'b0, irq}, 1);
        wr(8'h04, 32'h7);

        // R5 periodic ch1, divider 1
        wr(8'h00, 32'h2);
        wr(a_int(1), 4);
        wr(a_ctl(1), 32'h13);
        k = cyc;
        wait_irq(200, at);
        chk("R5 R4 first expiry", at - k, exp_first(4, 1));
        wr(8'h04, 32'h2);
        wait_irq(200, at2);
        chk("R5 period", at2 - at, exp_period(4, 1));
        wr(a_ctl(1), 0);
        idle(10);
        wr(8'h04, 32'h7);

        // R9 disable run-on on ch2
        wr(8'h00, 32'h0);
        wr(a_int(2), 1000);
        wr(a_ctl(2), 32'h03);
        idle(10);
        rd(a_cnt(2), v0);
        wr(a_ctl(2), 32'h0);
        rd(a_cnt(2), v); chk("R9 runon 1", v, v0 - 1);
        idle(1);
        rd(a_cnt(2), v); chk("R9 runon 2", v, v0 - 2);
        idle(1);
        rd(a_cnt(2), v); chk("R9 stopped", v, v0 - 3);
        idle(5);
        rd(a_cnt(2), v); chk("R9 holds", v, v0 - 3);
        rd(a_ctl(2), v); chk("R9 R2 ctl en low", v, 0);

        // R10 source 1, divider 1, interval 3, one-shot: 10 pulses
        wr(8'h00, 32'h4);
        wr(a_int(2), 3);
        wr(a_ctl(2), 32'h97);
        idle(20);
        rd(a_cnt(2), v); chk("R10 no ticks cnt", v, v0 - 3);
        rd(8'h04, v); chk("R10 no ticks status", v, 0);
        for (int i = 0; i < 9; i++) pulse_src1();
        chk("R10 after 9 pulses", {31'b0, irq}, 0);
        src_v[1] = 1'b1;
        @(negedge clk);
        src_v[1] = 1'b0;
        chk("R10 R4 after 10 pulses", {31'b0, irq}, 1);
        wr(8'h04, 32'h7);
        wr(8'h00, 32'h0);

        // R11 full range
        wr(a_int(0), 32'hFFFF_FFFF);
        wr(a_ctl(0), 32'h03);
        idle(6);
        rd(a_cnt(0), v); chk("R11 inverted count", ~v, 5);
        rd(a_ctl(0), v); chk("R2 load self-clear", v, 32'h01);
        wr(a_ctl(0), 0);
        idle(6);
        wr(8'h04, 32'h7);

        // random channel / interval / divider / mode
        for (int t = 0; t < 16; t++) begin
            int c, iv, p;
            bit per;
            c   = int'($urandom % 3);
            iv  = 1 + int'($urandom % 20);
            p   = int'($urandom % 4);
            per = 1'($urandom % 2);
            wr(8'h04, 32'h7);
            wr(8'h00, 32'(1 << c));
            wr(a_int(c), 32'(iv));
            wr(a_ctl(c), 32'(32'h03 | (p << 4) | (per ? 0 : 32'h80)));
            k = cyc;
            wait_irq(1000, at);
            chk("R3 R4 random expiry", at - k, exp_first(iv, p));
            if (per) begin
                wr(8'h04, 32'(1 << c));
                wait_irq(1000, at2);
                chk("R5 random period", at2 - at, exp_period(iv, p));
                wr(a_ctl(c), 0);
                idle(12);
            end else begin
                rd(a_ctl(c), v);
                chk("R6 random ctl", v, 32'(32'h80 | (p << 4)));
            end
        end
        wr(8'h04, 32'h7);
        chk("R7 R8 final clear", {31'b0, irq}, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule